// File: doc/BRIEF.md
# Line-Synchronised Horizontal Timing Sequencer

This block produces the horizontal timing for an image-sensor front end. A pixel counter runs on every clock and is forced back to zero a fixed number of clocks after the selected edge of the horizontal sync input. That fixed number is seven by default. A line counter advances with each of those pixel-counter restarts and is cleared by a falling edge on vertical sync. The line counter therefore gives the position of the current line inside a field. Three programmable line positions divide each field into up to four regions. The region in force selects a per-region pixel window that forms the internal horizontal blanking pulse.

Blanking can also come from an external pin with a programmable active level. When it does, the block also reports that the H1 clock must be held, and the level to hold it at. A 2-bit gain-steering phase advances along each line. It restarts together with the pixel counter, so the colour-pair steering stays aligned to the line. All settings are static configuration inputs. The sync inputs are asynchronous and are synchronised inside the block.

Top module: `line_timing_seq`

## Requirements
- R1: With `cfg_hd_edge`=0, if edge 0 is the first rising clock edge that samples `hd_in` low after a high level, then `pix_cnt` reads 0 after edge 7 (edge `SYNC_DLY`). It does not read 0 earlier because of that edge.
- R2: When no restart is due, `pix_cnt` increases by one per clock and wraps from 2^`PIX_W`-1 to 0.
- R3: With `cfg_hd_edge`=1, the rising edge of `hd_in` is used instead: if edge W is the first edge that samples it high, `pix_cnt` reads 0 after edge W+7. Falling edges are then ignored.
- R4: `line_cnt` increments, saturating at its maximum, on the same edge that zeroes `pix_cnt`. If edge v is the first edge that samples `vd_in` low, `line_cnt` reads 0 after edge v+2. A clear and an increment on the same edge give 0.
- R5: `region` is the highest index i in 1..3 whose start line (field i-1 of `cfg_region_line`, LSB first) is less than or equal to `line_cnt`, and 0 otherwise. It updates one clock after `line_cnt`.
- R6: With `cfg_blank_src`=0, `hblank` after an edge is 1 exactly when `pix_cnt` and `region` before that edge satisfy begin[region] <= `pix_cnt` < end[region]. Region k's begin and end are field k of `cfg_blank_begin` and `cfg_blank_end`, LSB first.
- R7: With `cfg_blank_src`=1, `hblank` after an edge is 1 exactly when `ext_blank_in` sampled at that edge equals `cfg_ext_pol`. A value of 1 means active high and 0 means active low.
- R8: `h1_force` is 1 only while external blanking is selected and active. `h1_level` equals `cfg_h1_mask` while `h1_force` is 1, and is 0 otherwise.
- R9: Bit 0 of `gain_phase` is 0 on the edge that zeroes `pix_cnt` and toggles on every other edge. Bit 1 toggles on each pixel-counter restart and is cleared together with `line_cnt` by vertical sync.
- R10: While `rst` is high, every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_in | input | 1 | Horizontal sync, asynchronous |
| vd_in | input | 1 | Vertical sync, asynchronous, falling edge starts a field |
| ext_blank_in | input | 1 | External blanking pin |
| cfg_hd_edge | input | 1 | 0 = falling hd edge, 1 = rising hd edge |
| cfg_blank_src | input | 1 | 0 = internal blanking, 1 = external pin |
| cfg_ext_pol | input | 1 | Active level of the external pin |
| cfg_h1_mask | input | 1 | Level H1 is held at during external blanking |
| cfg_region_line | input | (NREG-1)*LINE_W | Start lines of regions 1..NREG-1 |
| cfg_blank_begin | input | NREG*PIX_W | Per-region internal blanking start pixel |
| cfg_blank_end | input | NREG*PIX_W | Per-region internal blanking end pixel (exclusive) |
| pix_cnt | output | PIX_W | Pixel counter |
| line_cnt | output | LINE_W | Line counter within the field |
| region | output | $clog2(NREG) | Active clamp and blanking region |
| hblank | output | 1 | Horizontal blanking |
| h1_force | output | 1 | H1 must be held |
| h1_level | output | 1 | Level H1 is held at |
| gain_phase | output | 2 | Gain-steering phase {line parity, pixel parity} |

## Verification
The vertical-sync clear of the line counter and the line advance caused by the delayed horizontal restart can land on the same clock edge. The bench provokes this by pulling `vd_in` low five clocks after `hd_in`, so that both synchronised events reach the counter on edge 7. It then requires `line_cnt` to read 0, `gain_phase` to read 0 and `pix_cnt` to read 0 after that edge. It also runs a line where vertical sync arrives well after the restart, to confirm that the clear is applied on its own.

// File: rtl/lts_pkg.sv
package lts_pkg;
  // clock edges spent in the two-flop synchroniser before an edge is visible
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    HD_EDGE_FALL = 1'b0,
    HD_EDGE_RISE = 1'b1
  } hd_edge_e;

  typedef struct packed {
    logic ext_sel;
    logic ext_pol;
    logic mask_lvl;
  } blank_cfg_t;
endpackage

// File: rtl/lts_sync_edge.sv
module lts_sync_edge #(
  parameter int             N       = 2,
  parameter logic [N-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] meta_q, sync_q, hist_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[g] <= RST_VAL[g];
        sync_q[g] <= RST_VAL[g];
        hist_q[g] <= RST_VAL[g];
      end else begin
        meta_q[g] <= din[g];
        sync_q[g] <= meta_q[g];
        hist_q[g] <= sync_q[g];
      end
    end
    assign fall[g] = hist_q[g] & ~sync_q[g];
    assign rise[g] = ~hist_q[g] & sync_q[g];
  end
endmodule

// File: rtl/lts_hcount.sv
module lts_hcount #(
  parameter int PIX_W    = 12,
  parameter int SYNC_DLY = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hedge,
  output logic [PIX_W-1:0] pix_cnt,
  output logic             line_strobe
);
  // the synchroniser already consumed SYNC_STAGES of the delay
  localparam int LOAD = SYNC_DLY - lts_pkg::SYNC_STAGES;
  localparam int DW   = $clog2(LOAD + 1);

  logic [DW-1:0] dly_q;

  assign line_strobe = (dly_q == DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q   <= '0;
      pix_cnt <= '0;
    end else begin
      if (hedge)
        dly_q <= DW'(LOAD);
      else if (dly_q != '0)
        dly_q <= dly_q - DW'(1);

      if (line_strobe)
        pix_cnt <= '0;
      else
        pix_cnt <= pix_cnt + PIX_W'(1);
    end
  end
endmodule

// File: rtl/lts_vline.sv
module lts_vline #(
  parameter int LINE_W = 11,
  parameter int NREG   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          vd_fall,
  input  logic                          line_strobe,
  input  logic [(NREG-1)*LINE_W-1:0]    line_start,
  output logic [LINE_W-1:0]             line_cnt,
  output logic [$clog2(NREG)-1:0]       region
);
  localparam int RW = $clog2(NREG);

  logic [LINE_W-1:0] start_at [NREG];
  logic [RW-1:0]     sel;

  assign start_at[0] = '0;
  for (genvar g = 1; g < NREG; g++) begin : g_start
    assign start_at[g] = line_start[(g-1)*LINE_W +: LINE_W];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NREG; i++)
      if (line_cnt >= start_at[i]) sel = RW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt <= '0;
      region   <= '0;
    end else begin
      if (vd_fall)
        line_cnt <= '0;
      else if (line_strobe && line_cnt != '1)
        line_cnt <= line_cnt + LINE_W'(1);
      region <= sel;
    end
  end
endmodule

// File: rtl/lts_hout.sv
module lts_hout #(
  parameter int PIX_W = 12,
  parameter int NREG  = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PIX_W-1:0]           pix_cnt,
  input  logic [$clog2(NREG)-1:0]    region,
  input  logic                       ext_in,
  input  lts_pkg::blank_cfg_t        bcfg,
  input  logic [NREG*PIX_W-1:0]      win_begin,
  input  logic [NREG*PIX_W-1:0]      win_end,
  output logic                       hblank,
  output logic                       h1_force,
  output logic                       h1_level
);
  logic [PIX_W-1:0] wb [NREG];
  logic [PIX_W-1:0] we [NREG];
  logic             in_win, ext_act;

  for (genvar g = 0; g < NREG; g++) begin : g_win
    assign wb[g] = win_begin[g*PIX_W +: PIX_W];
    assign we[g] = win_end[g*PIX_W +: PIX_W];
  end

  always_comb begin
    in_win  = (pix_cnt >= wb[region]) && (pix_cnt < we[region]);
    ext_act = (ext_in == bcfg.ext_pol);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hblank   <= 1'b0;
      h1_force <= 1'b0;
      h1_level <= 1'b0;
    end else begin
      hblank   <= bcfg.ext_sel ? ext_act : in_win;
      h1_force <= bcfg.ext_sel & ext_act;
      h1_level <= bcfg.ext_sel & ext_act & bcfg.mask_lvl;
    end
  end
endmodule

// File: rtl/lts_gain.sv
module lts_gain (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_strobe,
  input  logic       vd_fall,
  output logic [1:0] gain_phase
);
  logic pix_ph, line_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_ph  <= 1'b0;
      line_ph <= 1'b0;
    end else begin
      pix_ph <= line_strobe ? 1'b0 : ~pix_ph;
      if (vd_fall)
        line_ph <= 1'b0;
      else if (line_strobe)
        line_ph <= ~line_ph;
    end
  end

  assign gain_phase = {line_ph, pix_ph};
endmodule

// File: rtl/line_timing_seq.sv
module line_timing_seq #(
  parameter int PIX_W    = 12,
  parameter int LINE_W   = 11,
  parameter int NREG     = 4,
  parameter int SYNC_DLY = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hd_in,
  input  logic                        vd_in,
  input  logic                        ext_blank_in,
  input  logic                        cfg_hd_edge,
  input  logic                        cfg_blank_src,
  input  logic                        cfg_ext_pol,
  input  logic                        cfg_h1_mask,
  input  logic [(NREG-1)*LINE_W-1:0]  cfg_region_line,
  input  logic [NREG*PIX_W-1:0]       cfg_blank_begin,
  input  logic [NREG*PIX_W-1:0]       cfg_blank_end,
  output logic [PIX_W-1:0]            pix_cnt,
  output logic [LINE_W-1:0]           line_cnt,
  output logic [$clog2(NREG)-1:0]     region,
  output logic                        hblank,
  output logic                        h1_force,
  output logic                        h1_level,
  output logic [1:0]                  gain_phase
);
  import lts_pkg::*;

  logic [1:0]  s_fall, s_rise;
  logic        hedge, vd_fall, h_strobe;
  blank_cfg_t  bcfg;

  lts_sync_edge #(.N(2), .RST_VAL(2'b11)) u_sync (
    .clk (clk), .rst (rst), .din ({vd_in, hd_in}),
    .fall(s_fall), .rise(s_rise)
  );

  assign hedge   = (hd_edge_e'(cfg_hd_edge) == HD_EDGE_RISE) ? s_rise[0] : s_fall[0];
  assign vd_fall = s_fall[1];

  lts_hcount #(.PIX_W(PIX_W), .SYNC_DLY(SYNC_DLY)) u_hcnt (
    .clk(clk), .rst(rst), .hedge(hedge),
    .pix_cnt(pix_cnt), .line_strobe(h_strobe)
  );

  lts_vline #(.LINE_W(LINE_W), .NREG(NREG)) u_vline (
    .clk(clk), .rst(rst), .vd_fall(vd_fall), .line_strobe(h_strobe),
    .line_start(cfg_region_line), .line_cnt(line_cnt), .region(region)
  );

  assign bcfg = '{ext_sel: cfg_blank_src, ext_pol: cfg_ext_pol, mask_lvl: cfg_h1_mask};

  lts_hout #(.PIX_W(PIX_W), .NREG(NREG)) u_hout (
    .clk(clk), .rst(rst), .pix_cnt(pix_cnt), .region(region),
    .ext_in(ext_blank_in), .bcfg(bcfg),
    .win_begin(cfg_blank_begin), .win_end(cfg_blank_end),
    .hblank(hblank), .h1_force(h1_force), .h1_level(h1_level)
  );

  lts_gain u_gain (
    .clk(clk), .rst(rst), .line_strobe(h_strobe), .vd_fall(vd_fall),
    .gain_phase(gain_phase)
  );
endmodule

// File: rtl/lts_checker.sv
module lts_checker #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              line_strobe,
  input logic              vd_fall,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [LINE_W-1:0] line_cnt,
  input logic              hblank,
  input logic              h1_force,
  input logic              h1_level,
  input logic [1:0]        gain_phase
);
  p_zero_after_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    line_strobe |=> pix_cnt == '0);

  p_line_clear_r4: assert property (@(posedge clk) disable iff (rst)
    vd_fall |=> line_cnt == '0);

  p_line_step_r4: assert property (@(posedge clk) disable iff (rst)
    (line_strobe && !vd_fall && line_cnt != '1) |=> line_cnt == $past(line_cnt) + LINE_W'(1));

  p_gain_restart_r9: assert property (@(posedge clk) disable iff (rst)
    line_strobe |=> gain_phase[0] == 1'b0);

  p_gain_alt_r9: assert property (@(posedge clk) disable iff (rst)
    !line_strobe |=> gain_phase[0] != $past(gain_phase[0]));

  p_force_blanks_r8: assert property (@(posedge clk) disable iff (rst)
    h1_force |-> hblank);

  p_level_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !h1_force |-> !h1_level);
endmodule

bind line_timing_seq lts_checker #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst(rst), .line_strobe(h_strobe), .vd_fall(vd_fall),
  .pix_cnt(pix_cnt), .line_cnt(line_cnt), .hblank(hblank),
  .h1_force(h1_force), .h1_level(h1_level), .gain_phase(gain_phase)
);

// File: tb/sim_line_timing_seq.sv
module sim_line_timing_seq;
  localparam int PW = 5;
  localparam int LW = 4;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hd_in = 1'b1, vd_in = 1'b1, ext_blank_in = 1'b0;
  logic cfg_hd_edge = 1'b0, cfg_blank_src = 1'b0, cfg_ext_pol = 1'b0, cfg_h1_mask = 1'b0;
  logic [(NR-1)*LW-1:0] cfg_region_line;
  logic [NR*PW-1:0]     cfg_blank_begin, cfg_blank_end;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;
  logic [1:0]    region;
  logic hblank, h1_force, h1_level;
  logic [1:0] gain_phase;

  always #5 clk = ~clk;

  line_timing_seq #(.PIX_W(PW), .LINE_W(LW), .NREG(NR), .SYNC_DLY(7)) u0 (.*);

  int errs = 0, total = 0, bl = 0;
  int bb[NR] = '{3, 0, 8, 12};
  int be[NR] = '{10, 5, 31, 12};
  int p_pix = 0, p_reg = 0;
  bit inv_on = 0, done = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int region_of(int l);
    return (l >= 6) ? 3 : (l >= 4) ? 2 : (l >= 2) ? 1 : 0;
  endfunction

  // sample after the edge, then check blanking and H1 outputs (R6, R7, R8)
  task automatic tick();
    int eb;
    @(negedge clk);
    if (inv_on) begin
      if (cfg_blank_src) begin
        eb = (ext_blank_in == cfg_ext_pol);
        chk("R7 hblank ext", int'(hblank), eb);
      end else begin
        eb = (p_pix >= bb[p_reg] && p_pix < be[p_reg]);
        chk("R6 hblank int", int'(hblank), eb);
      end
      chk("R8 h1_force", int'(h1_force), int'(cfg_blank_src) * eb);
      chk("R8 h1_level", int'(h1_level), int'(cfg_blank_src) * eb * int'(cfg_h1_mask));
    end
    p_pix = int'(pix_cnt);
    p_reg = int'(region);
  endtask

  // one line: hd pulse of W cycles at cycle 0, optional vd pulse at cycle v
  task automatic do_line(int L, int W, bit rise_mode, int v);
    int r;
    r = rise_mode ? W + 7 : 7;
    for (int i = 0; i < L; i++) begin
      int prev;
      prev = p_pix;
      hd_in = (i < W) ? 1'b0 : 1'b1;
      vd_in = (v >= 0 && i >= v && i < v + 3) ? 1'b0 : 1'b1;
      ext_blank_in = (((i * 5) + (bl * 3)) % 4) < 2;
      tick();
      if (i == r) begin
        bl = (v >= 0 && v + 2 == r) ? 0 : ((bl < 15) ? bl + 1 : bl);
        chk(rise_mode ? "R3 pix restart" : "R1 pix restart", int'(pix_cnt), 0);
        chk("R4 line advance/clear", int'(line_cnt), bl);
      end
      if (v >= 0 && i == v + 2 && v + 2 != r) begin
        bl = 0;
        chk("R4 vd clear", int'(line_cnt), 0);
      end
      if (i < r)
        chk("R2 pix step", int'(pix_cnt), (prev + 1) % 32);
      else
        chk("R2 pix count", int'(pix_cnt), (i - r) % 32);
      if (i >= r)
        chk("R9 gain phase", int'(gain_phase), (bl % 2) * 2 + ((i - r) % 2));
    end
    chk("R4 line at end", int'(line_cnt), bl);
    chk("R5 region", int'(region), region_of(bl));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      total++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    cfg_region_line = {4'd6, 4'd4, 4'd2};
    for (int k = 0; k < NR; k++) begin
      cfg_blank_begin[k*PW +: PW] = PW'(bb[k]);
      cfg_blank_end[k*PW +: PW]   = PW'(be[k]);
    end
    repeat (4) tick();
    // R10: outputs held at zero during reset
    chk("R10 pix", int'(pix_cnt), 0);
    chk("R10 line", int'(line_cnt), 0);
    chk("R10 region", int'(region), 0);
    chk("R10 blank/h1", int'({hblank, h1_force, h1_level}), 0);
    chk("R10 gain", int'(gain_phase), 0);
    rst = 1'b0;
    inv_on = 1;

    // field start by vd well after the restart
    do_line(30, 2, 0, 20);
    // region sweep through all four regions, varied pulse widths
    for (int k = 1; k <= 8; k++) do_line(30, 1 + (k % 4), 0, -1);
    // pixel counter wrap (R2)
    do_line(45, 1, 0, -1);
    // vd clear and line advance on the same edge (R4, R9)
    do_line(30, 3, 0, 5);
    do_line(30, 2, 0, -1);
    // rising-edge restart (R3)
    cfg_hd_edge = 1'b1;
    for (int w = 2; w <= 4; w++) do_line(40, w, 1, -1);
    cfg_hd_edge = 1'b0;
    // external blanking: all polarity and mask-level combinations (R7, R8)
    cfg_blank_src = 1'b1;
    for (int c = 0; c < 4; c++) begin
      cfg_ext_pol = c[0];
      cfg_h1_mask = c[1];
      do_line(30, 1, 0, -1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule